// File: doc/BRIEF.md
# USB Full-Speed Line State Detector

This block watches the two single-ended receiver outputs of a full-speed (12 Mbit/s) USB pair and turns them into the line information a device controller needs. It passes both inputs through a two-stage synchronizer and samples them on a fixed 48 MHz clock, which gives four samples per bit time. Each sample falls into one of four classes: single-ended zero (both low), J (plus high, minus low: a data one and the idle level), K (plus low, minus high: a data zero and the resume level) and the illegal single-ended one (both high).

On top of that classification it measures how long each condition lasts. A single-ended zero about two bit times long that is followed by one bit time of idle is an end of packet. A single-ended zero that persists past a long threshold (default 121 samples, a little over 2.5 µs) is a bus reset if the device was connected at that point, and a disconnect otherwise. A non-zero line that persists past the same threshold makes the device connected. Start of packet is a J-to-K transition seen while no packet is open. Single-cycle pulses mark start of packet, end of packet and reset entry. Levels report connection, reset, disconnect and the illegal state.

Top module: `usb_line_state_detector`

## Requirements
- R1: `line_state_o` shows the synchronized line as {minus, plus}: 2'b00 single-ended zero, 2'b01 J, 2'b10 K, 2'b11 single-ended one. A change at the inputs that is sampled at rising edge n appears after rising edge n+2.
- R2: `se1_err_o` is high exactly while the reported line is single-ended one. That sample never counts as J or K for start or end of packet.
- R3: `sop_o` pulses for one cycle on the first K sample that directly follows a J sample while no packet is open. The pulse opens a packet, and any single-ended zero sample closes it, so J-to-K transitions inside a packet give no pulse.
- R4: `eop_o` pulses for one cycle on the fourth consecutive J sample that follows a single-ended zero run of 6 to 10 samples.
- R5: No end-of-packet pulse follows a single-ended zero run shorter than 6 or longer than 10 samples, or one whose following idle is broken before four J samples.
- R6: `connected_o` rises on the 121st consecutive sample that is not single-ended zero. It stays high until a single-ended zero run reaches 121 samples.
- R7: When a single-ended zero run reaches 121 samples while `connected_o` is high, `reset_start_o` pulses for that one cycle and `bus_reset_o` rises, `connected_o` falls in the same cycle, and `bus_reset_o` stays high until the first sample that is not single-ended zero.
- R8: When a single-ended zero run reaches 121 samples while `connected_o` is low, `disconnected_o` rises and stays high until the first sample that is not single-ended zero. It is never high together with `bus_reset_o`.
- R9: The duration counters saturate. A single-ended zero run of any length, however long, gives exactly one `reset_start_o` pulse, and the levels hold for the whole run.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_i | input | 1 | Plus-line receiver output, asynchronous |
| dm_i | input | 1 | Minus-line receiver output, asynchronous |
| line_state_o | output | 2 | Synchronized line class {minus, plus} |
| se1_err_o | output | 1 | Illegal both-high state |
| sop_o | output | 1 | Start-of-packet pulse |
| eop_o | output | 1 | End-of-packet pulse |
| connected_o | output | 1 | Device connected level |
| bus_reset_o | output | 1 | Bus reset in progress level |
| reset_start_o | output | 1 | Bus reset entry pulse |
| disconnected_o | output | 1 | Long zero while not connected |

## Verification
The bench targets the edges of the end-of-packet window: runs of 3 and 14 zero samples, and an idle interrupted after two J samples. A design with a loose window or no idle count would pulse `eop_o` there. It holds the line at single-ended zero for 400 samples, so a counter that wraps instead of saturating would fire a second reset pulse. It also sends a packet with inner J-to-K edges, where a design without the open-packet state would flag repeated starts. Finally it checks the connected history that separates reset from disconnect, where a swapped decision would raise the wrong level.

// File: rtl/usb_line_state_detector.sv
module usb_line_state_detector #(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int LONG_SAMPLES    = 121
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic [1:0] line_state_o,
  output logic       se1_err_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       connected_o,
  output logic       bus_reset_o,
  output logic       reset_start_o,
  output logic       disconnected_o
);
  localparam int CW      = $clog2(LONG_SAMPLES + 1);
  localparam int EOP_MIN = 2 * SAMPLES_PER_BIT - SAMPLES_PER_BIT / 2;
  localparam int EOP_MAX = 2 * SAMPLES_PER_BIT + SAMPLES_PER_BIT / 2;
  localparam int AW      = $clog2(SAMPLES_PER_BIT + 1);
  localparam logic [CW-1:0] LONG_C = CW'(LONG_SAMPLES);
  localparam logic [CW-1:0] LONG_M1 = CW'(LONG_SAMPLES - 1);
  localparam logic [CW-1:0] EMIN_C = CW'(EOP_MIN);
  localparam logic [CW-1:0] EMAX_C = CW'(EOP_MAX);
  localparam logic [AW-1:0] IDLE_C = AW'(SAMPLES_PER_BIT);

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;
  localparam logic [1:0] LS_SE1 = 2'b11;

  logic [1:0]    s1, s2;
  logic [CW-1:0] se0_cnt, hi_cnt, se0_nx, hi_nx;
  logic [AW-1:0] arm, arm_nx;
  logic          in_pkt;

  wire is_se0 = (s2 == LS_SE0);
  wire is_j   = (s2 == LS_J);
  wire is_k   = (s2 == LS_K);

  assign se0_nx = !is_se0 ? '0 : (se0_cnt == LONG_C) ? LONG_C : se0_cnt + 1'b1;
  assign hi_nx  =  is_se0 ? '0 : (hi_cnt == LONG_C)  ? LONG_C : hi_cnt + 1'b1;

  wire long_se0_hit = is_se0 && (se0_cnt == LONG_M1);
  wire long_hi_hit  = !is_se0 && (hi_cnt == LONG_M1);
  wire eop_len_ok   = (se0_cnt >= EMIN_C) && (se0_cnt <= EMAX_C);

  always_comb begin
    arm_nx = '0;
    if (is_j) begin
      if (eop_len_ok)      arm_nx = AW'(1);
      else if (arm != '0)  arm_nx = arm + 1'b1;
    end
  end

  wire eop_hit = is_j && (arm_nx == IDLE_C);
  wire sop_hit = is_k && (line_state_o == LS_J) && !in_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {dm_i, dp_i};
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      se0_cnt        <= '0;
      hi_cnt         <= '0;
      arm            <= '0;
      in_pkt         <= 1'b0;
      line_state_o   <= LS_SE0;
      se1_err_o      <= 1'b0;
      sop_o          <= 1'b0;
      eop_o          <= 1'b0;
      connected_o    <= 1'b0;
      bus_reset_o    <= 1'b0;
      reset_start_o  <= 1'b0;
      disconnected_o <= 1'b0;
    end else begin
      se0_cnt       <= se0_nx;
      hi_cnt        <= hi_nx;
      arm           <= eop_hit ? '0 : arm_nx;
      line_state_o  <= s2;
      se1_err_o     <= (s2 == LS_SE1);
      sop_o         <= sop_hit;
      eop_o         <= eop_hit;
      reset_start_o <= long_se0_hit && connected_o;

      if (sop_hit)     in_pkt <= 1'b1;
      else if (is_se0) in_pkt <= 1'b0;

      if (long_se0_hit)     connected_o <= 1'b0;
      else if (long_hi_hit) connected_o <= 1'b1;

      if (long_se0_hit && connected_o) bus_reset_o <= 1'b1;
      else if (!is_se0)                bus_reset_o <= 1'b0;

      if (long_se0_hit && !connected_o) disconnected_o <= 1'b1;
      else if (!is_se0)                 disconnected_o <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_lsd_checker.sv
module usb_lsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_state_o,
  input logic       se1_err_o,
  input logic       sop_o,
  input logic       eop_o,
  input logic       connected_o,
  input logic       bus_reset_o,
  input logic       reset_start_o,
  input logic       disconnected_o
);
  assert_se1_not_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    se1_err_o |-> !sop_o && !eop_o);
  assert_sop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |=> !sop_o);
  assert_sop_on_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> line_state_o == 2'b10);
  assert_eop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !eop_o);
  assert_eop_on_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> line_state_o == 2'b01);
  assert_reset_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_start_o |-> bus_reset_o && !connected_o);
  assert_reset_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_reset_o) |-> reset_start_o);
  assert_reset_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_start_o |=> !reset_start_o);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_reset_o && disconnected_o));
  assert_disc_not_conn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disconnected_o |-> !connected_o);
endmodule

bind usb_line_state_detector usb_lsd_checker u_lsd_checker (
  .clk(clk), .rst_n(rst_n), .line_state_o(line_state_o), .se1_err_o(se1_err_o),
  .sop_o(sop_o), .eop_o(eop_o), .connected_o(connected_o),
  .bus_reset_o(bus_reset_o), .reset_start_o(reset_start_o),
  .disconnected_o(disconnected_o)
);

// File: tb/usb_line_state_detector_bench.sv
`timescale 1ns/1ps
module usb_line_state_detector_bench;
  localparam int LONG = 121;
  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0;
  logic [1:0] ls;
  logic se1, sop, eop, conn, brst, rstart, disc;
  int checks = 0, errors = 0;
  int eop_seen = 0, rst_seen = 0;

  always #10 clk = ~clk;

  usb_line_state_detector u_usb_line_state_detector (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .line_state_o(ls),
    .se1_err_o(se1), .sop_o(sop), .eop_o(eop), .connected_o(conn),
    .bus_reset_o(brst), .reset_start_o(rstart), .disconnected_o(disc));

  // behavioural reference
  int hist[$];
  int m_ls, m_se0, m_hi, m_arm;
  bit m_pkt, m_sop, m_eop, m_conn, m_brst, m_rst, m_disc, m_se1;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_ls = 0; m_se0 = 0; m_hi = 0; m_arm = 0; m_pkt = 0;
      m_sop = 0; m_eop = 0; m_conn = 0; m_brst = 0; m_rst = 0; m_disc = 0; m_se1 = 0;
    end else begin
      int c, prev;
      bit long_zero;
      hist.push_back({dm, dp});
      if (hist.size() > 3) void'(hist.pop_front());
      c = (hist.size() >= 3) ? hist[0] : 0;
      prev = m_ls;
      long_zero = (c == 0) && (m_se0 == LONG - 1);
      m_sop = (c == 2) && (prev == 1) && !m_pkt;
      if (m_sop) m_pkt = 1; else if (c == 0) m_pkt = 0;
      m_eop = 0;
      if (c == 1) begin
        if (m_se0 >= 6 && m_se0 <= 10) m_arm = 1;
        else if (m_arm > 0) m_arm++;
        if (m_arm == 4) begin m_eop = 1; m_arm = 0; end
      end else m_arm = 0;
      m_rst = long_zero && m_conn;
      if (c != 0) begin m_brst = 0; m_disc = 0; end
      if (long_zero) begin
        if (m_conn) m_brst = 1; else m_disc = 1;
        m_conn = 0;
      end
      if (c != 0 && m_hi == LONG - 1) m_conn = 1;
      m_se0 = (c == 0) ? ((m_se0 < LONG) ? m_se0 + 1 : LONG) : 0;
      m_hi  = (c != 0) ? ((m_hi < LONG) ? m_hi + 1 : LONG) : 0;
      m_ls = c;
      m_se1 = (c == 3);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk({ls, se1, sop, eop, conn, brst, rstart, disc} == 9'd0, "R10 reset outputs",
          {ls, se1, sop, eop, conn, brst, rstart, disc}, 0);
    end else begin
      chk(ls == m_ls[1:0], "R1 line_state", ls, m_ls);
      chk(se1 == m_se1, "R2 se1_err", se1, m_se1);
      chk(sop == m_sop, "R3 sop", sop, m_sop);
      chk(eop == m_eop, "R4 eop", eop, m_eop);
      chk(conn == m_conn, "R6 connected", conn, m_conn);
      chk(brst == m_brst, "R7 bus_reset", brst, m_brst);
      chk(rstart == m_rst, "R7 reset_start", rstart, m_rst);
      chk(disc == m_disc, "R8 disconnected", disc, m_disc);
      if (eop) eop_seen++;
      if (rstart) rst_seen++;
    end
  end

  task automatic drive(input logic [1:0] v, input int n);
    {dm, dp} = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    drive(2'b01, 200);                         // R6 connect after long idle
    chk(conn == 1'b1, "R6 connected after idle", conn, 1);
    drive(2'b10, 4); drive(2'b01, 4); drive(2'b10, 4); drive(2'b01, 4);
    drive(2'b10, 8); drive(2'b00, 8); drive(2'b01, 12);   // good packet: R3 R4
    chk(eop_seen == 1, "R4 eop count", eop_seen, 1);
    eop_seen = 0;
    drive(2'b10, 4); drive(2'b00, 3);  drive(2'b01, 10);  // too short
    drive(2'b10, 4); drive(2'b00, 14); drive(2'b01, 10);  // too long
    drive(2'b10, 4); drive(2'b00, 8);  drive(2'b01, 2);
    drive(2'b10, 4); drive(2'b01, 10);                    // idle broken
    chk(eop_seen == 0, "R5 no eop on bad shapes", eop_seen, 0);
    drive(2'b11, 5); drive(2'b10, 4); drive(2'b01, 10);  // R2 illegal state
    drive(2'b00, 400);                                    // R7 R9 long reset
    chk(brst == 1'b1 && conn == 1'b0, "R7 reset level", {brst, conn}, 2);
    chk(rst_seen == 1, "R9 single reset pulse", rst_seen, 1);
    drive(2'b01, 50);
    chk(brst == 1'b0, "R7 reset ends", brst, 0);
    drive(2'b00, 200);                                    // R8 disconnect
    chk(disc == 1'b1 && brst == 1'b0, "R8 disconnect level", {disc, brst}, 2);
    drive(2'b01, 200);
    chk(disc == 1'b0 && conn == 1'b1, "R6 reconnect", {disc, conn}, 1);
    finish_run();
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule